// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one byte at a time into an asynchronous serial character on a single output line. A producer offers a byte with a valid/ready handshake. Once the byte is accepted, the block sends a low start bit, then the data bits least significant first, then an optional parity bit, then a high stop period. The line rests high between characters.

The character format comes from a set of static control inputs: a two-bit word-length code, a stop-select bit, a parity-enable bit and a parity-type bit. The block copies these inputs at the moment it accepts a byte, so changing them during a character has no effect on that character. All timing is counted in pulses of an external baud tick that runs at sixteen times the bit rate. This lets the block produce a half-length stop period. A divisor, FIFO storage and modem lines are supplied elsewhere.

Top module: `serial_frame_tx`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `tx_out` is 1 and `in_ready` is 1.
- R2: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both 1. On the next cycle `tx_out` is 0 (start bit). The start bit is followed by the data bits LSB first and then a stop period at 1. The line is 1 whenever no character is in progress.
- R3: `cfg_len` selects the number of data bits sent: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Bits of `in_data` above the selected length are never sent.
- R4: With `cfg_stop` at 0, the stop period lasts 16 baud ticks for every word length.
- R5: With `cfg_stop` at 1 and `cfg_len` at 00, the stop period lasts 24 baud ticks (one and a half bits).
- R6: With `cfg_stop` at 1 and `cfg_len` at 01, 10 or 11, the stop period lasts 32 baud ticks (two bits).
- R7: With `cfg_par_en` at 1, one parity bit follows the last data bit. With `cfg_par_en` at 0, the stop period follows the last data bit directly.
- R8: `cfg_par_even` at 0 selects odd parity, so the sent data bits plus the parity bit contain an odd number of ones. At 1 it selects even parity.
- R9: The start bit, each data bit and the parity bit each last exactly 16 baud ticks. The line changes only on the clock edge that carries the tick ending a bit.
- R10: The control inputs are captured when a byte is accepted. Changing them during a character does not alter that character.
- R11: `in_ready` is 0 from the cycle after acceptance until the tick that ends the stop period, and 1 on the cycle after that tick. An `in_valid` pulse while `in_ready` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | DATA_W | Byte to send |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block idle and able to accept a byte |
| cfg_len | input | 2 | Word-length code (00=5 … 11=8 bits) |
| cfg_stop | input | 1 | Stop-select: 0 one bit, 1 longer stop period |
| cfg_par_en | input | 1 | Send a parity bit |
| cfg_par_even | input | 1 | Parity type: 0 odd, 1 even |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| tx_out | output | 1 | Serial line, idles at 1 |

## Verification
The assertions watch properties that hold on every cycle. The line is high whenever the block is idle or in its stop period. The cycle after an acceptance shows a low line with ready deasserted. The tick counter never reaches its current limit. The data bit index stays inside the captured word length. The captured format holds steady for the whole character. Only the bench's scenarios can show the timing and content of whole characters: the exact tick count of each stop option, the parity value for each type, the LSB-first bit order, and the fact that a mid-character change of the control inputs or a stray valid pulse leaves the character untouched.

// File: rtl/sftx_pkg.sv
package sftx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_START  = 3'd1,
    PH_DATA   = 3'd2,
    PH_PARITY = 3'd3,
    PH_STOP   = 3'd4
  } sftx_phase_e;

  localparam int MIN_WORD = 5;
endpackage

// File: rtl/sftx_frame_cfg.sv
module sftx_frame_cfg #(
  parameter int DATA_W = 8,
  parameter int TPB    = 16,
  parameter int CNT_W  = 6,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [1:0]        len,
  input  logic              stop_sel,
  input  logic              par_en,
  input  logic              par_even,
  input  logic [DATA_W-1:0] data,
  output logic [IDX_W-1:0]  nbits,
  output logic              par_on,
  output logic              par_bit,
  output logic [CNT_W-1:0]  stop_ticks
);
  logic [IDX_W-1:0]  len_bits;
  logic [DATA_W-1:0] keep;
  logic              ones;
  logic              par_calc;
  logic [CNT_W-1:0]  stop_calc;

  assign len_bits = IDX_W'(sftx_pkg::MIN_WORD) + IDX_W'(len);

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign keep[i] = (IDX_W'(i) < len_bits);
  end

  assign ones     = ^(data & keep);
  assign par_calc = par_even ? ones : ~ones;

  always_comb begin
    if (!stop_sel)      stop_calc = CNT_W'(TPB);
    else if (len == 2'b00) stop_calc = CNT_W'(TPB + TPB / 2);
    else                stop_calc = CNT_W'(2 * TPB);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nbits      <= IDX_W'(sftx_pkg::MIN_WORD);
      par_on     <= 1'b0;
      par_bit    <= 1'b0;
      stop_ticks <= CNT_W'(TPB);
    end else if (load) begin
      nbits      <= len_bits;
      par_on     <= par_en;
      par_bit    <= par_calc;
      stop_ticks <= stop_calc;
    end
  end

  AST_FMT_HELD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(stop_ticks) && $stable(nbits) && $stable(par_bit)) else $error("format changed without load"); // R10
endmodule

// File: rtl/sftx_tick_count.sv
module sftx_tick_count #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  assign done = tick && (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clear)  cnt <= '0;
    else if (done)     cnt <= '0;
    else if (tick)     cnt <= cnt + CNT_W'(1);
  end

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    !clear |-> cnt < limit) else $error("tick count ran past limit"); // R9
endmodule

// File: rtl/sftx_shift.sv
module sftx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] data,
  output logic              cur_lsb,
  output logic              nxt_lsb
);
  logic [DATA_W-1:0] sr;

  assign cur_lsb = sr[0];
  assign nxt_lsb = sr[1];

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (load)  sr <= data;
    else if (shift) sr <= {1'b0, sr[DATA_W-1:1]};
  end
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_stop,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              baud_tick,
  output logic              tx_out
);
  import sftx_pkg::*;

  localparam int CNT_W = $clog2(2 * TICKS_PER_BIT + 1);
  localparam int IDX_W = $clog2(DATA_W + 1);

  sftx_phase_e      phase, phase_n;
  logic [IDX_W-1:0] bit_idx, bit_idx_n;
  logic             line_n;
  logic             accept;
  logic             bit_done;
  logic             shift_en;
  logic [CNT_W-1:0] limit;
  logic [IDX_W-1:0] nbits;
  logic             par_on, par_bit;
  logic [CNT_W-1:0] stop_ticks;
  logic             cur_lsb, nxt_lsb;

  assign in_ready = (phase == PH_IDLE);
  assign accept   = in_valid && in_ready;
  assign limit    = (phase == PH_STOP) ? stop_ticks : CNT_W'(TICKS_PER_BIT);

  sftx_frame_cfg #(
    .DATA_W(DATA_W), .TPB(TICKS_PER_BIT), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .load(accept),
    .len(cfg_len), .stop_sel(cfg_stop), .par_en(cfg_par_en), .par_even(cfg_par_even),
    .data(in_data),
    .nbits(nbits), .par_on(par_on), .par_bit(par_bit), .stop_ticks(stop_ticks)
  );

  sftx_tick_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clear(in_ready), .tick(baud_tick),
    .limit(limit), .done(bit_done)
  );

  sftx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load(accept), .shift(shift_en), .data(in_data),
    .cur_lsb(cur_lsb), .nxt_lsb(nxt_lsb)
  );

  always_comb begin
    phase_n   = phase;
    bit_idx_n = bit_idx;
    line_n    = tx_out;
    shift_en  = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        line_n = 1'b1;
        if (accept) begin
          phase_n = PH_START;
          line_n  = 1'b0;
        end
      end
      PH_START: begin
        if (bit_done) begin
          phase_n   = PH_DATA;
          bit_idx_n = '0;
          line_n    = cur_lsb;
        end
      end
      PH_DATA: begin
        if (bit_done) begin
          if (bit_idx == nbits - IDX_W'(1)) begin
            phase_n = par_on ? PH_PARITY : PH_STOP;
            line_n  = par_on ? par_bit : 1'b1;
          end else begin
            bit_idx_n = bit_idx + IDX_W'(1);
            shift_en  = 1'b1;
            line_n    = nxt_lsb;
          end
        end
      end
      PH_PARITY: begin
        if (bit_done) begin
          phase_n = PH_STOP;
          line_n  = 1'b1;
        end
      end
      PH_STOP: begin
        line_n = 1'b1;
        if (bit_done) phase_n = PH_IDLE;
      end
      default: begin
        phase_n = PH_IDLE;
        line_n  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      bit_idx <= '0;
      tx_out  <= 1'b1;
    end else begin
      phase   <= phase_n;
      bit_idx <= bit_idx_n;
      tx_out  <= line_n;
    end
  end

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> tx_out) else $error("line low while idle"); // R2
  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    accept |=> !tx_out && !in_ready) else $error("no start bit after accept"); // R11
  AST_STOP_MARK: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_STOP) |-> tx_out) else $error("line low during stop"); // R2
  AST_IDX_IN_WORD: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DATA) |-> bit_idx < nbits) else $error("data index past word"); // R3
endmodule

// File: tb/serial_frame_tx_tb.sv
module serial_frame_tx_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] cfg_len = '0;
  logic       cfg_stop = 1'b0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic       baud_tick = 1'b0;
  logic       tx_out;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  serial_frame_tx u_dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .cfg_len(cfg_len), .cfg_stop(cfg_stop), .cfg_par_en(cfg_par_en),
    .cfg_par_even(cfg_par_even), .baud_tick(baud_tick), .tx_out(tx_out)
  );

  // {data[7:0], len[1:0], stop, par_en, par_even, frame_ticks[7:0]}
  localparam int NV = 12;
  localparam logic [20:0] VEC [NV] = '{
    {8'hA5, 2'd0, 1'b0, 1'b0, 1'b0, 8'd112},
    {8'h3C, 2'd1, 1'b0, 1'b1, 1'b0, 8'd144},
    {8'h5A, 2'd2, 1'b0, 1'b1, 1'b1, 8'd160},
    {8'hFF, 2'd3, 1'b0, 1'b0, 1'b0, 8'd160},
    {8'h13, 2'd0, 1'b1, 1'b0, 1'b0, 8'd120},
    {8'h1F, 2'd0, 1'b1, 1'b1, 1'b1, 8'd136},
    {8'h2A, 2'd1, 1'b1, 1'b0, 1'b0, 8'd144},
    {8'h81, 2'd3, 1'b1, 1'b1, 1'b0, 8'd192},
    {8'h00, 2'd3, 1'b0, 1'b1, 1'b0, 8'd176},
    {8'h00, 2'd2, 1'b1, 1'b1, 1'b1, 8'd176},
    {8'hC7, 2'd2, 1'b0, 1'b0, 1'b0, 8'd144},
    {8'h96, 2'd1, 1'b1, 1'b1, 1'b0, 8'd160}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic model_level(input logic [7:0] d, input logic [1:0] len,
                                       input logic pe, input logic pev, input int k);
    int nb = 5 + int'(len);
    int b  = k / 16;
    logic [7:0] m = 8'hFF >> (8 - nb);
    logic ones = ^(d & m);
    if (b == 0) return 1'b0;
    if (b <= nb) return d[b-1];
    if (pe && b == nb + 1) return pev ? ones : ~ones;
    return 1'b1;
  endfunction

  task automatic run_frame(input logic [7:0] d, input logic [1:0] len, input logic st,
                           input logic pe, input logic pev, input int nticks,
                           input bit perturb, input string tag);
    int mism = 0;
    int first_k = -1;
    bit busy_ok = 1'b1;
    @(negedge clk);
    in_data = d; cfg_len = len; cfg_stop = st; cfg_par_en = pe; cfg_par_even = pev;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(!tx_out && !in_ready, {tag, " R2 R11 start"}, {30'd0, tx_out, in_ready}, 0);
    if (perturb) begin
      cfg_len = ~len; cfg_stop = ~st; cfg_par_en = ~pe; cfg_par_even = ~pev;
      in_data = ~d;
    end
    for (int k = 0; k < nticks; k++) begin
      if (tx_out !== model_level(d, len, pe, pev, k)) begin
        mism++;
        if (first_k < 0) first_k = k;
      end
      if (in_ready) busy_ok = 1'b0;
      if (perturb && k == 40) in_valid = 1'b1;
      if (perturb && k == 42) in_valid = 1'b0;
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
      @(negedge clk);
    end
    check(mism == 0, {tag, " R3 R7 R8 R9 waveform"}, first_k, -1);
    check(busy_ok, {tag, " R4 R5 R6 R11 busy until last tick"}, 0, 1);
    check(in_ready && tx_out, {tag, " R4 R5 R6 R11 idle after last tick"},
          {30'd0, in_ready, tx_out}, 3);
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(tx_out && in_ready, "R1 during reset", {30'd0, tx_out, in_ready}, 3);
    rst = 1'b0;
    @(negedge clk);
    check(tx_out && in_ready, "R1 after reset", {30'd0, tx_out, in_ready}, 3);

    for (int v = 0; v < NV; v++) begin
      run_frame(VEC[v][20:13], VEC[v][12:11], VEC[v][10], VEC[v][9], VEC[v][8],
                int'(VEC[v][7:0]), 1'b0, $sformatf("vec%0d", v));
    end

    // R10 and R11: inputs change and a stray valid arrives during the character
    run_frame(8'h6D, 2'd1, 1'b0, 1'b1, 1'b1, 144, 1'b1, "directed R10 R11");
    in_valid = 1'b0;
    for (int k = 0; k < 20; k++) begin
      baud_tick = 1'b1; @(negedge clk); baud_tick = 1'b0; @(negedge clk);
    end
    check(in_ready && tx_out, "R11 stray valid ignored", {30'd0, in_ready, tx_out}, 3);

    // R1: reset in the middle of a character
    run_frame(8'h01, 2'd0, 1'b0, 1'b0, 1'b0, 112, 1'b0, "pre-reset R2");
    @(negedge clk);
    in_data = 8'h00; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 5; k++) begin
      baud_tick = 1'b1; @(negedge clk); baud_tick = 1'b0; @(negedge clk);
    end
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(tx_out && in_ready, "R1 mid-frame reset", {30'd0, tx_out, in_ready}, 3);
    run_frame(8'h15, 2'd0, 1'b1, 1'b1, 1'b0, 136, 1'b0, "post-reset R5");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule